// File: doc/BRIEF.md
# DVB-ASI Sync-Filling 8b/10b Encoder Front-End

This block sits between a transport-stream source and a serializer running at the asynchronous serial interface line rate. Each parallel clock it takes one 20-bit input word. The word carries a transport byte and two control flags in its upper bits. The block produces one 10-bit 8b/10b code group, tracking running disparity from one group to the next. The source may have no byte ready, for example when its FIFO runs dry. It then raises the sync-insert flag, and the block sends the K28.5 comma in place of the byte. The comma passes through the same encoder, so it also carries the correct disparity.

The input is checked and the comma substituted in a first register stage. The encoder sits in the second stage, which registers the code group. A small two-state machine holds the running disparity. Its states are RD_NEG and RD_POS. It takes the FLIP transition after any code group with an unequal count of ones and zeros, and the HOLD transition after a balanced one. Each word in the first stage falls into one of four kinds: SEL_SYNC (comma substitution), SEL_CTRL (valid control character), SEL_BADK (control flag on a byte that is not a control character) and SEL_DATA.

Top module: `dvb_sync_tx`

## Requirements
- R1: Input bit 19 is the sync-insert request and input bit 18 is the control-character flag. Bits 17..10 hold the byte, with bit 17 as its MSB. Bits 17..15 are the 3-bit HGF field and bits 14..10 the 5-bit EDCBA field.
- R2: With both flags low, the byte is encoded as a data character using the standard 5b/6b and 3b/4b tables. The alternate form of D.x.7 is used for x = 17, 18, 20 at negative disparity and for x = 11, 13, 14 at positive disparity. Code bit 9 is line bit a, down to code bit 0, which is line bit j.
- R3: While sync-insert is high, the code group is K28.5, whatever the flag and byte are: 0x0FA at negative disparity and 0x305 at positive disparity. No error is flagged.
- R4: With the control flag high and sync-insert low, the bytes 0x1C, 0x3C, 0x5C, 0x7C, 0x9C, 0xBC, 0xDC, 0xFC, 0xF7, 0xFB, 0xFD and 0xFE are encoded as control characters K28.0-K28.7, K23.7, K27.7, K29.7 and K30.7.
- R5: With the control flag high on any other byte and sync-insert low, the block emits K28.5 and raises kerr_q. kerr_q is high in the same cycle as that code group and for that group only.
- R6: Running disparity is negative after reset. The first code group after reset is the idle comma K28.5 at negative disparity (0x0FA).
- R7: A word sampled at clock edge n appears on code_q and kerr_q after edge n+1, which is a fixed latency of two clocks.
- R8: While reset is low, code_q is 0 and kerr_q is 0.
- R9: Input bits 9..0 have no effect on any output.
- R10: Every code group has four, five or six ones. After a group, the disparity is RD_POS only if that group had at least five ones, and RD_NEG only if it had at most five.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parallel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 20 | Input word: sync request, control flag, byte, unused low bits |
| code_q | output | 10 | Registered 8b/10b code group, bit 9 sent first |
| kerr_q | output | 1 | Invalid control character replaced by the comma |

## Verification
Every code group and its kerr_q value are due two rising edges after the input word is applied. The one exception is the idle comma, which is due one edge after reset is released. The bench drives each word on a falling edge and samples on the falling edges in between. It compares the result for word i at the falling edge two cycles after word i was driven, so every comparison falls half a period after the register that produces it. One directed case applies a single data word between commas. It checks that the word is not yet visible after one edge and is visible after the second. Reset is asynchronous, so its clearing of the outputs is checked one nanosecond after reset falls.

// File: rtl/dvbs_pkg.sv
`timescale 1ns/1ps
package dvbs_pkg;
    localparam int OCT_W   = 8;
    localparam int SIX_W   = 6;
    localparam int FOUR_W  = 4;
    localparam int CODE_W  = SIX_W + FOUR_W;
    localparam int LOW_W   = 5;
    localparam int HIGH_W  = OCT_W - LOW_W;

    localparam logic [OCT_W-1:0]  COMMA_BYTE = 8'hBC;
    localparam logic [CODE_W-1:0] K285_NEG   = 10'h0FA;
    localparam logic [CODE_W-1:0] K285_POS   = 10'h305;

    typedef enum logic {
        RD_NEG = 1'b0,
        RD_POS = 1'b1
    } rd_e;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_SYNC = 2'd2,
        SEL_BADK = 2'd3
    } sel_e;

    typedef struct packed {
        logic [OCT_W-1:0] octet;
        logic             is_k;
        logic             bad_k;
    } sym_t;
endpackage

// File: rtl/dvbs_unpack.sv
`timescale 1ns/1ps
module dvbs_unpack
    import dvbs_pkg::*;
#(
    parameter int BUS_W     = 20,
    parameter int SYNC_POS  = 19,
    parameter int KFLAG_POS = 18,
    parameter int OCT_LSB   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] din,
    output sym_t             sym_q
);
    localparam int OCT_MSB = OCT_LSB + OCT_W - 1;

    logic             sync_req;
    logic             k_req;
    logic [OCT_W-1:0] oct;
    logic             k_legal;
    sel_e             sel;
    sym_t             sym_d;
    logic             unused_low;

    assign sync_req   = din[SYNC_POS];
    assign k_req      = din[KFLAG_POS];
    assign oct        = din[OCT_MSB:OCT_LSB];
    assign unused_low = ^din[OCT_LSB-1:0];

    // Legal control characters: K28.y for any y, and K23/27/29/30 with y = 7.
    always_comb begin
        k_legal = (oct[LOW_W-1:0] == 5'd28);
        if (oct[OCT_W-1:LOW_W] == 3'd7) begin
            if (oct[LOW_W-1:0] == 5'd23 || oct[LOW_W-1:0] == 5'd27 ||
                oct[LOW_W-1:0] == 5'd29 || oct[LOW_W-1:0] == 5'd30)
                k_legal = 1'b1;
        end
    end

    // Classify the word; the sync request outranks everything else.
    always_comb begin
        if (sync_req)
            sel = SEL_SYNC;
        else if (k_req && k_legal)
            sel = SEL_CTRL;
        else if (k_req)
            sel = SEL_BADK;
        else
            sel = SEL_DATA;
    end

    always_comb begin
        sym_d = '{octet: oct, is_k: 1'b0, bad_k: 1'b0};
        unique case (sel)
            SEL_SYNC: sym_d = '{octet: COMMA_BYTE, is_k: 1'b1, bad_k: 1'b0};
            SEL_CTRL: sym_d = '{octet: oct,        is_k: 1'b1, bad_k: 1'b0};
            SEL_BADK: sym_d = '{octet: COMMA_BYTE, is_k: 1'b1, bad_k: 1'b1};
            SEL_DATA: sym_d = '{octet: oct,        is_k: 1'b0, bad_k: 1'b0};
        endcase
    end

    // Reset leaves an idle comma queued for the encoder.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sym_q <= '{octet: COMMA_BYTE, is_k: 1'b1, bad_k: 1'b0};
        else
            sym_q <= sym_d;
    end

    assert_sync_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sync_req |=> (sym_q.octet == COMMA_BYTE && sym_q.is_k && !sym_q.bad_k))
        else $error("sync request did not queue a comma");

    assert_ctrl_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_req && k_req && oct == 8'h3C) |=> (sym_q.octet == 8'h3C && sym_q.is_k && !sym_q.bad_k))
        else $error("legal control byte was altered");

    assert_badk_comma_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sym_q.bad_k |-> (sym_q.octet == COMMA_BYTE && sym_q.is_k))
        else $error("invalid control byte not replaced");
endmodule

// File: rtl/dvbs_enc8b10b.sv
`timescale 1ns/1ps
module dvbs_enc8b10b
    import dvbs_pkg::*;
(
    input  logic [OCT_W-1:0]  octet,
    input  logic              is_k,
    input  rd_e               rd_in,
    output logic [CODE_W-1:0] code,
    output logic              flip
);
    // Negative-disparity form of each 6-bit sub-block, bits abcdei with a as MSB.
    function automatic logic [SIX_W-1:0] six_neg(input logic [LOW_W-1:0] x);
        case (x)
            5'd0:  six_neg = 6'b100111;
            5'd1:  six_neg = 6'b011101;
            5'd2:  six_neg = 6'b101101;
            5'd3:  six_neg = 6'b110001;
            5'd4:  six_neg = 6'b110101;
            5'd5:  six_neg = 6'b101001;
            5'd6:  six_neg = 6'b011001;
            5'd7:  six_neg = 6'b111000;
            5'd8:  six_neg = 6'b111001;
            5'd9:  six_neg = 6'b100101;
            5'd10: six_neg = 6'b010101;
            5'd11: six_neg = 6'b110100;
            5'd12: six_neg = 6'b001101;
            5'd13: six_neg = 6'b101100;
            5'd14: six_neg = 6'b011100;
            5'd15: six_neg = 6'b010111;
            5'd16: six_neg = 6'b011011;
            5'd17: six_neg = 6'b100011;
            5'd18: six_neg = 6'b010011;
            5'd19: six_neg = 6'b110010;
            5'd20: six_neg = 6'b001011;
            5'd21: six_neg = 6'b101010;
            5'd22: six_neg = 6'b011010;
            5'd23: six_neg = 6'b111010;
            5'd24: six_neg = 6'b110011;
            5'd25: six_neg = 6'b100110;
            5'd26: six_neg = 6'b010110;
            5'd27: six_neg = 6'b110110;
            5'd28: six_neg = 6'b001110;
            5'd29: six_neg = 6'b101110;
            5'd30: six_neg = 6'b011110;
            default: six_neg = 6'b101011;
        endcase
    endfunction

    logic [LOW_W-1:0]  x;
    logic [HIGH_W-1:0] y;
    logic [SIX_W-1:0]  six_base;
    logic [SIX_W-1:0]  six;
    logic [FOUR_W-1:0] four_base;
    logic [FOUR_W-1:0] four;
    logic              six_unbal;
    logic              four_unbal;
    logic              alt7;
    rd_e               rd_mid;

    always_comb begin
        x = octet[LOW_W-1:0];
        y = octet[OCT_W-1:LOW_W];

        // 6-bit sub-block
        six_base  = (is_k && x == 5'd28) ? 6'b001111 : six_neg(x);
        six_unbal = ($countones(six_base) != 3);
        if (rd_in == RD_POS && (six_unbal || x == 5'd7))
            six = ~six_base;
        else
            six = six_base;
        if (six_unbal)
            rd_mid = (rd_in == RD_POS) ? RD_NEG : RD_POS;
        else
            rd_mid = rd_in;

        // 4-bit sub-block, chosen by the disparity left by the 6-bit part
        alt7 = is_k ||
               (rd_mid == RD_NEG && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
               (rd_mid == RD_POS && (x == 5'd11 || x == 5'd13 || x == 5'd14));
        case (y)
            3'd0:    four_base = 4'b1011;
            3'd1:    four_base = 4'b1001;
            3'd2:    four_base = 4'b0101;
            3'd3:    four_base = 4'b1100;
            3'd4:    four_base = 4'b1101;
            3'd5:    four_base = 4'b1010;
            3'd6:    four_base = 4'b0110;
            default: four_base = alt7 ? 4'b0111 : 4'b1110;
        endcase
        four_unbal = ($countones(four_base) != 2);
        if (rd_mid == RD_POS && (four_unbal || y == 3'd3))
            four = ~four_base;
        else if (is_k && rd_mid == RD_NEG && !four_unbal && y != 3'd3)
            four = ~four_base;
        else
            four = four_base;

        code = {six, four};
        flip = (six_unbal != four_unbal);
    end

    always_comb begin
        if (!$isunknown(code)) begin
            assert_code_weight_R10: assert ($countones(code) >= 4 && $countones(code) <= 6)
                else $error("code group weight out of range");
        end
    end
endmodule

// File: rtl/dvb_sync_tx.sv
`timescale 1ns/1ps
module dvb_sync_tx
    import dvbs_pkg::*;
#(
    parameter int BUS_W     = 20,
    parameter int SYNC_POS  = 19,
    parameter int KFLAG_POS = 18,
    parameter int OCT_LSB   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_W-1:0]  din,
    output logic [CODE_W-1:0] code_q,
    output logic              kerr_q
);
    sym_t              s1;
    logic [CODE_W-1:0] enc_code;
    logic              enc_flip;
    rd_e               rd_q;
    rd_e               rd_nx;

    dvbs_unpack #(
        .BUS_W     (BUS_W),
        .SYNC_POS  (SYNC_POS),
        .KFLAG_POS (KFLAG_POS),
        .OCT_LSB   (OCT_LSB)
    ) u_unpack (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (din),
        .sym_q (s1)
    );

    dvbs_enc8b10b u_enc (
        .octet (s1.octet),
        .is_k  (s1.is_k),
        .rd_in (rd_q),
        .code  (enc_code),
        .flip  (enc_flip)
    );

    // Disparity state machine: FLIP on an unbalanced group, HOLD otherwise.
    always_comb begin
        rd_nx = rd_q;
        unique case (rd_q)
            RD_NEG: rd_nx = enc_flip ? RD_POS : RD_NEG;
            RD_POS: rd_nx = enc_flip ? RD_NEG : RD_POS;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rd_q <= RD_NEG;
        else
            rd_q <= rd_nx;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            kerr_q <= 1'b0;
        end else begin
            code_q <= enc_code;
            kerr_q <= s1.bad_k;
        end
    end

    assert_rd_weight_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q != '0) |-> ((rd_q == RD_POS) ? ($countones(code_q) >= 5) : ($countones(code_q) <= 5)))
        else $error("disparity state disagrees with emitted group");

    assert_kerr_comma_R5: assert property (@(posedge clk) disable iff (!rst_n)
        kerr_q |-> (code_q == K285_NEG || code_q == K285_POS))
        else $error("error flag without a comma");

    assert_stage_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s1.is_k && s1.octet == COMMA_BYTE) |=> (code_q == K285_NEG || code_q == K285_POS))
        else $error("queued comma did not reach the output one edge later");
endmodule

// File: tb/sim_dvb_sync_tx.sv
`timescale 1ns/1ps
module sim_dvb_sync_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [19:0] din;
    logic [9:0] code_q;
    logic       kerr_q;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dvb_sync_tx u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (din),
        .code_q (code_q),
        .kerr_q (kerr_q)
    );

    // {sync, kflag, byte, low bits, expected code, expected kerr}; disparity starts + (after idle comma)
    localparam int NV = 19;
    localparam logic [30:0] VEC [NV] = '{
        {1'b1, 1'b0, 8'h00, 10'h155, 10'h305, 1'b0}, // R3 comma at RD+
        {1'b0, 1'b0, 8'h00, 10'h000, 10'h274, 1'b0}, // R2 D0.0 RD-
        {1'b0, 1'b0, 8'hB5, 10'h3FF, 10'h2AA, 1'b0}, // R9 D21.5
        {1'b0, 1'b0, 8'h07, 10'h0AA, 10'h38B, 1'b0}, // R9 D7.0 RD-
        {1'b0, 1'b0, 8'h67, 10'h111, 10'h073, 1'b0}, // R9 D7.3 RD+
        {1'b0, 1'b0, 8'hEB, 10'h000, 10'h348, 1'b0}, // R2 D11.7 alternate
        {1'b0, 1'b0, 8'hF1, 10'h2C3, 10'h237, 1'b0}, // R9 D17.7 alternate
        {1'b0, 1'b0, 8'hFF, 10'h000, 10'h14E, 1'b0}, // R2 D31.7 primary
        {1'b0, 1'b1, 8'h1C, 10'h001, 10'h30B, 1'b0}, // R4 K28.0 RD+
        {1'b0, 1'b1, 8'hF7, 10'h000, 10'h057, 1'b0}, // R4 K23.7 RD+
        {1'b0, 1'b1, 8'h00, 10'h3FF, 10'h305, 1'b1}, // R5 invalid K
        {1'b1, 1'b1, 8'h00, 10'h000, 10'h0FA, 1'b0}, // R3 sync wins over bad K
        {1'b0, 1'b0, 8'h00, 10'h3FF, 10'h18B, 1'b0}, // R9 D0.0 RD+
        {1'b0, 1'b1, 8'h3C, 10'h000, 10'h306, 1'b0}, // R4 K28.1 RD+
        {1'b0, 1'b1, 8'hBC, 10'h200, 10'h0FA, 1'b0}, // R4 K28.5 RD-
        {1'b0, 1'b0, 8'h23, 10'h000, 10'h319, 1'b0}, // R2 D3.1
        {1'b0, 1'b0, 8'hEE, 10'h000, 10'h1C8, 1'b0}, // R2 D14.7 alternate
        {1'b0, 1'b0, 8'hF4, 10'h3FF, 10'h0B7, 1'b0}, // R9 D20.7 alternate
        {1'b0, 1'b1, 8'hFE, 10'h000, 10'h217, 1'b0}  // R4 K30.7 RD+
    };

    localparam logic [19:0] SYNC_WORD = 20'h80000;

    task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [30:0] v);
        if (v[30])               return "R3";
        else if (v[0])           return "R5";
        else if (v[29])          return "R4";
        else if (v[20:11] != 0)  return "R9";
        else                     return "R2";
    endfunction

    function automatic logic [9:0] weight_ok(input logic [9:0] c);
        return ($countones(c) >= 4 && $countones(c) <= 6) ? 10'd1 : 10'd0;
    endfunction

    initial begin
        din = SYNC_WORD;
        repeat (3) @(negedge clk);
        check("R8 code in reset", code_q, 10'h000);
        check("R8 kerr in reset", {9'b0, kerr_q}, 10'h000);
        rst_n = 1'b1;

        // vector walk: word i driven here, its result due two falling edges later
        for (int i = 0; i < NV + 2; i++) begin
            if (i == 1)
                check("R6 idle comma after reset", code_q, 10'h0FA);
            if (i >= 2) begin
                check({"R1 ", tag_of(VEC[i-2]), " code"}, code_q, VEC[i-2][10:1]);
                check({"R1 ", tag_of(VEC[i-2]), " kerr"}, {9'b0, kerr_q}, {9'b0, VEC[i-2][0]});
                check("R10 group weight", weight_ok(code_q), 10'd1);
            end
            if (i < NV)
                din = VEC[i][30:11];
            else
                din = SYNC_WORD;
            @(negedge clk);
        end

        // mid-stream reset: outputs clear at once, disparity restarts negative
        rst_n = 1'b0;
        #1;
        check("R8 code cleared by reset", code_q, 10'h000);
        check("R8 kerr cleared by reset", {9'b0, kerr_q}, 10'h000);
        @(negedge clk);
        din = 20'h00000;
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 comma at RD- after reset", code_q, 10'h0FA);
        din = SYNC_WORD;
        @(negedge clk);
        check("R6 disparity follows restart", code_q, 10'h18B);

        // two-clock latency of a lone data word
        @(negedge clk);
        din = {2'b00, 8'hB5, 10'h000};
        @(negedge clk);
        check("R7 not visible after one edge",
              (code_q == 10'h0FA || code_q == 10'h305) ? 10'd1 : 10'd0, 10'd1);
        din = SYNC_WORD;
        @(negedge clk);
        check("R7 visible after two edges", code_q, 10'h2AA);
        check("R7 no error on data", {9'b0, kerr_q}, 10'h000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule